// File: doc/BRIEF.md
# I2C Master START Generator with Collision Detection

This block produces the START condition for an I2C bus master and watches the bus for collisions while it does so. Software asks for a START with a one-cycle request strobe. The block releases both lines and checks that SDA and SCL both read high. It then times two intervals with a baud-rate down-counter:

- At the end of the first interval it pulls SDA low.
- At the end of the second interval it pulls SCL low.

The line inputs pass through a synchronizer before any decision is based on them.

The block handles three abnormal line conditions:

- **SCL drops while SDA is still high and released.** Another master is assumed to be sending a '1', so the block aborts with a collision.
- **SDA drops early, during the first interval.** This is not a collision. The block pulls SDA at once and restarts the timer.
- **SCL drops during the second interval.** This is tolerated.

Two sticky flags report the result: one for success and one for collision. Software clears each flag with its own write-one-to-clear strobe. After a successful START the block holds both lines low for the transfer that follows. A new request first releases them.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset every output is 0: both pull-low enables, the start-enable bit, both flags and the START-seen bit.
- R2: A `start_set` pulse while idle sets `start_en`, which is visible one cycle after the sampling edge. A `start_set` pulse while `start_en` is already 1 is ignored, and the timing of the START in progress does not change.
- R3: If either line reads low at the initial check, the START is aborted. `coll_flag` goes to 1, `start_en` goes to 0, and no line is pulled. All three take effect on the 3rd clock edge after the request edge.
- R4: In the clean case, `sda_pull` rises on edge reload+4 after the request edge. This count is two synchronizer cycles, one check cycle and reload+1 countdown cycles. A reload of zero gives a single countdown cycle.
- R5: In the clean case, `scl_pull` rises reload+1 cycles after `sda_pull`. On that same edge `done_flag` and `start_seen` go to 1 and `start_en` goes to 0.
- R6: If SCL reads low while SDA reads high during the first interval, the START is aborted with `coll_flag` = 1. Both pull enables are 0 and `start_en` is 0 on the edge that sets the flag.
- R7: If SDA goes low externally during the first interval, `sda_pull` rises 3 edges after the line change. The counter restarts, `scl_pull` follows reload+1 cycles later, and no collision is flagged.
- R8: SCL driven low externally during the second interval is not a collision. The START completes on time.
- R9: `done_flag` and `coll_flag` stay 1 until their own clear strobe (`done_clr`, `coll_clr`). A clear strobe has no effect on the other flag.
- R10: `start_seen` is cleared when a new request is accepted. It stays 0 after a collision abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_set | input | 1 | One-cycle request to begin a START |
| done_clr | input | 1 | Write-one-to-clear strobe for done_flag |
| coll_clr | input | 1 | Write-one-to-clear strobe for coll_flag |
| reload | input | CNT_W | Baud-rate reload value (interval = reload+1 cycles) |
| sda_in | input | 1 | Sampled SDA line level (asynchronous) |
| scl_in | input | 1 | Sampled SCL line level (asynchronous) |
| start_en | output | 1 | Start-enable bit, cleared by the block on completion or abort |
| sda_pull | output | 1 | Open-drain pull-low enable for SDA |
| scl_pull | output | 1 | Open-drain pull-low enable for SCL |
| done_flag | output | 1 | Sticky START-complete interrupt flag |
| start_seen | output | 1 | START-detected status bit |
| coll_flag | output | 1 | Sticky bus-collision flag |

## Verification
The hardest situations to reach are the ones that depend on when the other master acts:

- SCL pulled low inside the first interval but before its last cycle.
- SDA pulled low early enough that the early-pull path gives a different edge count than a normal timeout.

The bench models the bus as a wired-AND of the block's pull enables and two external pull-downs. It asserts an external pull-down at a chosen negedge offset from the request edge. It then checks the exact edge on which each pull enable rises. The offsets are chosen so that the synchronizer latency puts the decision well inside the intended interval.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CHECK,
        ST_WAIT_SDA,
        ST_WAIT_SCL
    } st_e;

    typedef struct packed {
        st_e  st;
        logic en;
        logic sda_pull;
        logic scl_pull;
        logic done;
        logic coll;
        logic seen;
    } ctl_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = load_val;
        else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
    import i2c_start_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_set,
    input  logic             done_clr,
    input  logic             coll_clr,
    input  logic [CNT_W-1:0] reload,
    input  logic             sda_s,
    input  logic             scl_s,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_load_val,
    output logic             cnt_dec,
    output ctl_t             ctl
);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SYNC_STAGES - 1);

    ctl_t q, d;
    logic set_done, set_coll;

    always_comb begin
        d            = q;
        cnt_load     = 1'b0;
        cnt_load_val = reload;
        cnt_dec      = 1'b0;
        set_done     = 1'b0;
        set_coll     = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_set) begin
                    d.en         = 1'b1;
                    d.sda_pull   = 1'b0;
                    d.scl_pull   = 1'b0;
                    d.seen       = 1'b0;
                    cnt_load     = 1'b1;
                    cnt_load_val = SETTLE_LD;
                    d.st         = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (cnt_zero) d.st = ST_CHECK;
                else          cnt_dec = 1'b1;
            end
            ST_CHECK: begin
                if (!sda_s || !scl_s) begin
                    set_coll = 1'b1;
                end else begin
                    cnt_load = 1'b1;
                    d.st     = ST_WAIT_SDA;
                end
            end
            ST_WAIT_SDA: begin
                if (!scl_s && sda_s) begin
                    set_coll = 1'b1;
                end else if (!sda_s || cnt_zero) begin
                    d.sda_pull = 1'b1;
                    cnt_load   = 1'b1;
                    d.st       = ST_WAIT_SCL;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_WAIT_SCL: begin
                if (cnt_zero) begin
                    d.scl_pull = 1'b1;
                    d.seen     = 1'b1;
                    d.en       = 1'b0;
                    set_done   = 1'b1;
                    d.st       = ST_IDLE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (set_coll) begin
            d.en       = 1'b0;
            d.sda_pull = 1'b0;
            d.scl_pull = 1'b0;
            d.st       = ST_IDLE;
        end
        d.done = set_done | (q.done & ~done_clr);
        d.coll = set_coll | (q.coll & ~coll_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: 1'b0};
        else        q <= d;
    end

    assign ctl = q;

    // R6
    coll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.coll) |-> (!q.sda_pull && !q.scl_pull && !q.en));
    // R5
    scl_after_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.scl_pull) |-> (q.sda_pull && q.done && q.seen));
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && start_set) |=> q.en);
    // R3
    end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.en) |-> (q.done || q.coll));
    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !done_clr) |=> q.done);
    // R9
    coll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.coll && !coll_clr) |=> q.coll);
    // R7
    sda_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sda_pull) |-> $past(q.st) == ST_WAIT_SDA);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2c_start_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_set,
    input  logic             done_clr,
    input  logic             coll_clr,
    input  logic [CNT_W-1:0] reload,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             start_en,
    output logic             sda_pull,
    output logic             scl_pull,
    output logic             done_flag,
    output logic             start_seen,
    output logic             coll_flag
);
    logic             sda_s, scl_s;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_load_val;
    ctl_t             ctl;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

    i2c_baud_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
        .dec(cnt_dec), .zero(cnt_zero));

    i2c_start_fsm #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .done_clr(done_clr),
        .coll_clr(coll_clr), .reload(reload), .sda_s(sda_s), .scl_s(scl_s),
        .cnt_zero(cnt_zero), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .cnt_dec(cnt_dec), .ctl(ctl));

    assign start_en   = ctl.en;
    assign sda_pull   = ctl.sda_pull;
    assign scl_pull   = ctl.scl_pull;
    assign done_flag  = ctl.done;
    assign start_seen = ctl.seen;
    assign coll_flag  = ctl.coll;
endmodule

// File: tb/i2c_start_gen_test.sv
module i2c_start_gen_test;
    typedef struct packed {
        logic [7:0] reload;
        logic       pre_sda;
        logic       pre_scl;
        logic [7:0] mid_sda;
        logic [7:0] mid_scl;
        logic       coll;
        logic [7:0] sda_n;
        logic [7:0] scl_n;
        logic [7:0] end_n;
    } vec_t;

    // mid_* = 0: no external pull; sda_n/scl_n = 0: never pulled
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 1'b0, 1'b0, 8'd0, 8'd0,  1'b0, 8'd4, 8'd5,  8'd5},   // R4 R5
        '{8'd3, 1'b0, 1'b0, 8'd0, 8'd0,  1'b0, 8'd7, 8'd11, 8'd11},  // R4 R5
        '{8'd5, 1'b1, 1'b0, 8'd0, 8'd0,  1'b1, 8'd0, 8'd0,  8'd3},   // R3
        '{8'd5, 1'b0, 1'b1, 8'd0, 8'd0,  1'b1, 8'd0, 8'd0,  8'd3},   // R3
        '{8'd6, 1'b0, 1'b0, 8'd0, 8'd4,  1'b1, 8'd0, 8'd0,  8'd7},   // R6
        '{8'd6, 1'b0, 1'b0, 8'd5, 8'd0,  1'b0, 8'd8, 8'd15, 8'd15},  // R7
        '{8'd4, 1'b0, 1'b0, 8'd0, 8'd10, 1'b0, 8'd8, 8'd13, 8'd13},  // R8
        '{8'd4, 1'b0, 1'b0, 8'd3, 8'd0,  1'b0, 8'd6, 8'd11, 8'd11}   // R7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_set = 1'b0, done_clr = 1'b0, coll_clr = 1'b0;
    logic [7:0] reload = '0;
    logic       ext_sda = 1'b0, ext_scl = 1'b0;
    logic       start_en, sda_pull, scl_pull, done_flag, start_seen, coll_flag;
    logic       sda_in, scl_in;
    int         n_chk = 0, n_bad = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    assign sda_in = ~(sda_pull | ext_sda);
    assign scl_in = ~(scl_pull | ext_scl);

    i2c_start_gen uut (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .done_clr(done_clr),
        .coll_clr(coll_clr), .reload(reload), .sda_in(sda_in), .scl_in(scl_in),
        .start_en(start_en), .sda_pull(sda_pull), .scl_pull(scl_pull),
        .done_flag(done_flag), .start_seen(start_seen), .coll_flag(coll_flag));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic run_vec(input vec_t v, input int resend_at);
        int sda_first = 0, scl_first = 0, end_first = 0;
        @(negedge clk);
        reload    = v.reload;
        ext_sda   = v.pre_sda;
        ext_scl   = v.pre_scl;
        start_set = 1'b1;
        @(posedge clk);
        for (int n = 0; n <= 40; n++) begin
            @(negedge clk);
            if (n == 0) begin
                start_set = 1'b0;
                check(start_en == 1'b1, "R2 start_en set", start_en, 1);
            end
            if (sda_pull && sda_first == 0) sda_first = n;
            if (scl_pull && scl_first == 0) scl_first = n;
            if (!start_en && end_first == 0) begin
                end_first = n;
                if (v.coll) check(!sda_pull && !scl_pull, "R6 pulls released",
                                  {sda_pull, scl_pull}, 0);
            end
            if (resend_at != 0 && n == resend_at)     start_set = 1'b1;
            if (resend_at != 0 && n == resend_at + 1) start_set = 1'b0;
            if (v.mid_sda != 0 && n == int'(v.mid_sda)) ext_sda = 1'b1;
            if (v.mid_scl != 0 && n == int'(v.mid_scl)) ext_scl = 1'b1;
        end
        check(sda_first == int'(v.sda_n), "R4/R7 sda_pull edge", sda_first, v.sda_n);
        check(scl_first == int'(v.scl_n), "R5/R8 scl_pull edge", scl_first, v.scl_n);
        check(end_first == int'(v.end_n), "R3/R5 start_en clear edge", end_first, v.end_n);
        check(coll_flag == v.coll, "R3/R6/R8 coll_flag", coll_flag, v.coll);
        check(done_flag == !v.coll, "R5 done_flag", done_flag, !v.coll);
        check(start_seen == !v.coll, "R10 start_seen", start_seen, !v.coll);
        ext_sda = 1'b0;
        ext_scl = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        done_clr = 1'b1;
        coll_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        coll_clr = 1'b0;
        check(!done_flag && !coll_flag, "R9 flags cleared", {done_flag, coll_flag}, 0);
    endtask

    initial begin
        #(10 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({start_en, sda_pull, scl_pull, done_flag, start_seen, coll_flag} == '0,
              "R1 reset state",
              {start_en, sda_pull, scl_pull, done_flag, start_seen, coll_flag}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 0);
            clear_flags();
        end

        // R2: a second request while busy is ignored
        run_vec(VECS[1], 4);
        clear_flags();

        // R9: collision flag is sticky and not cleared by the other strobe
        run_vec(VECS[2], 0);
        repeat (20) @(negedge clk);
        check(coll_flag == 1'b1, "R9 coll sticky", coll_flag, 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check(coll_flag == 1'b1, "R9 done_clr leaves coll", coll_flag, 1);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        check(coll_flag == 1'b0, "R9 coll_clr clears", coll_flag, 0);

        // R9: done flag is sticky and not cleared by coll_clr
        run_vec(VECS[0], 0);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        check(done_flag == 1'b1, "R9 coll_clr leaves done", done_flag, 1);
        // R10: a new request clears start_seen
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        check(start_seen == 1'b0, "R10 seen cleared on accept", start_seen, 0);
        repeat (12) @(negedge clk);
        clear_flags();

        finish_run();
    end
endmodule